// File: doc/BRIEF.md
# ADC Acquisition and Conversion Sequencer

This block is the control state machine that walks one analog-to-digital channel through acquisition (sample-hold closed) and then conversion. All of its timing is counted in conversion-clock ticks. A single-cycle strobe marks each tick. A 3-bit source select picks what ends acquisition:
- software clearing a sample bit;
- a self-timed count of ticks (auto-start);
- one of three external event pulses.

Conversion always lasts a fixed number of ticks. At the end, the value from the converter is stored in a result register and a one-cycle done pulse is raised.

Dropping the enable input during acquisition or conversion aborts the sequence. The result register keeps its last completed value. The block then enforces a recovery wait, counted in ticks, before it will sample again. External event pulses are asynchronous. They pass through a two-flop synchronizer and a rising-edge detector, and each detected edge is held pending until the next tick.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, sample_hold, converting, done and result are all zero.
- R2: With source select 000 (software), acquisition begins on the cycle after enable and sample bit are both high. Conversion begins at the first tick seen while the sample bit is low.
- R3: With source select 111 (auto-start), acquisition begins on the cycle after enable is high. Conversion begins on the N-th tick of acquisition, where N is the auto-sample count. After each result, acquisition restarts by itself.
- R4: An auto-sample count of 0 behaves exactly like a count of 1: conversion begins on the first tick of acquisition.
- R5: Conversion lasts 12 ticks. With a regular tick every P cycles, converting is high for 12*P cycles. At the 12th tick the converter word is stored in result, converting falls, and done is high for exactly that one following cycle.
- R6: Source select 001, 010 and 011 use external pulse bit 0 (timer), bit 1 (PWM) and bit 2 (interrupt) respectively. A rising edge passes a two-flop synchronizer and an edge detector, and is held pending until the next tick, where it starts conversion if the sequencer is in acquisition. An edge on a bit that is not selected starts nothing.
- R7: Source select values 100, 101 and 110 never end acquisition: sample_hold stays high, converting stays low and no done is raised.
- R8: Enable low during acquisition or conversion stops the sequence on the next cycle. No done is raised, and result keeps its last completed value.
- R9: When enable goes low on the same cycle as the tick that would start an auto-start conversion, the abort wins and converting does not rise.
- R10: After an abort, sampling cannot restart until 2 ticks have passed, even if enable is high again at once.
- R11: sample_hold and converting are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Converter on; low aborts any sequence in progress |
| samp_sw | input | 1 | Software sample bit (used with source select 000) |
| trig_sel | input | 3 | Conversion start source select |
| auto_cnt | input | SAMP_W (5) | Acquisition length in ticks for auto-start mode |
| tick | input | 1 | One-cycle conversion-clock tick strobe |
| ext_trig | input | NUM_EXT (3) | Asynchronous external event pulses: timer, PWM, interrupt |
| conv_data | input | DATA_W (10) | Word from the converter model |
| sample_hold | output | 1 | High while acquiring |
| converting | output | 1 | High while converting |
| result | output | DATA_W (10) | Last completed conversion result |
| done | output | 1 | One-cycle pulse when result is written |

## Verification
The bench builds the block with its defaults: 10-bit data, a 5-bit auto-sample count, 12 conversion ticks and a 2-tick recovery wait. With a 5-bit count, both the zero count and short counts are reachable in a few hundred cycles. A tick period of 2 or 3 cycles keeps each 12-tick conversion short enough that auto-start repeats many times within a test. The bench can read the reference model's tick counter, which lets it drop enable on exactly the cycle of an auto-start tick, so the abort-versus-start priority is hit on purpose.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_SOFT = 3'd0;
  localparam logic [SEL_W-1:0] SEL_AUTO = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int NUM_EXT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [NUM_EXT-1:0] ext_in,
  output logic [NUM_EXT-1:0] pend
);
  logic [NUM_EXT-1:0] meta_q, sync_q, prev_q, rise;

  assign rise = sync_q & ~prev_q;

  generate
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q[i] <= 1'b0;
          sync_q[i] <= 1'b0;
          prev_q[i] <= 1'b0;
          pend[i]   <= 1'b0;
        end else begin
          meta_q[i] <= ext_in[i];
          sync_q[i] <= meta_q[i];
          prev_q[i] <= sync_q[i];
          // a tick consumes the pending edge; an edge on that same cycle waits for the next tick
          pend[i]   <= tick ? rise[i] : (pend[i] | rise[i]);
        end
      end

      assert_pend_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !rise[i]) |=> !pend[i]);
    end
  endgenerate
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SAMP_W      = 5,
  parameter int CONV_TICKS  = 12,
  parameter int ABORT_TICKS = 2,
  parameter int NUM_EXT     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              samp_sw,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [SAMP_W-1:0] auto_cnt,
  input  logic              tick,
  input  logic [NUM_EXT-1:0] pend,
  output logic              sh_q,
  output logic              cv_q,
  output logic              conv_end
);
  localparam int SAMP_MAX = (1 << SAMP_W) - 1;
  localparam int CNT_MAX  = (SAMP_MAX > CONV_TICKS) ?
                            ((SAMP_MAX > ABORT_TICKS) ? SAMP_MAX : ABORT_TICKS) :
                            ((CONV_TICKS > ABORT_TICKS) ? CONV_TICKS : ABORT_TICKS);
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_TICKS - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(ABORT_TICKS - 1);

  seq_state_t       state, state_d;
  logic [CNT_W-1:0] cnt, cnt_d, cnt_inc, eff;
  logic             ext_hit;

  assign cnt_inc = cnt + CNT_W'(1);
  assign eff     = (auto_cnt == '0) ? CNT_W'(1) : CNT_W'(auto_cnt);

  always_comb begin
    ext_hit = 1'b0;
    for (int i = 0; i < NUM_EXT; i++)
      if (trig_sel == SEL_W'(i + 1)) ext_hit = ext_hit | pend[i];
  end

  always_comb begin
    state_d  = state;
    cnt_d    = cnt;
    conv_end = 1'b0;
    case (state)
      ST_IDLE:
        if (enable && (trig_sel != SEL_SOFT || samp_sw)) begin
          state_d = ST_ACQ;
          cnt_d   = '0;
        end
      ST_ACQ:
        if (!enable) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end else if (tick) begin
          if (trig_sel == SEL_AUTO) begin
            if (cnt_inc >= eff) begin
              state_d = ST_CONV;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_inc;
            end
          end else if (trig_sel == SEL_SOFT) begin
            if (!samp_sw) begin
              state_d = ST_CONV;
              cnt_d   = '0;
            end
          end else if (ext_hit) begin
            state_d = ST_CONV;
            cnt_d   = '0;
          end
        end
      ST_CONV:
        if (!enable) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end else if (tick) begin
          if (cnt == CONV_LAST) begin
            state_d  = ST_IDLE;
            cnt_d    = '0;
            conv_end = 1'b1;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      default:
        if (tick) begin
          if (cnt == WAIT_LAST) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sh_q  <= 1'b0;
      cv_q  <= 1'b0;
    end else begin
      state <= state_d;
      cnt   <= cnt_d;
      sh_q  <= (state_d == ST_ACQ);
      cv_q  <= (state_d == ST_CONV);
    end
  end

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(sh_q && cv_q));
  assert_conv_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cv_q) |-> $past(tick && sh_q));
  assert_zero_count_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACQ && enable && tick && trig_sel == SEL_AUTO && auto_cnt == '0) |=> cv_q);
  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (rst)
    (cv_q && !enable) |=> !cv_q);
  assert_abort_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (sh_q && !enable) |=> !cv_q);
  assert_wait_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !tick) |=> (state == ST_WAIT));
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_end,
  input  logic [DATA_W-1:0] conv_data,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= conv_end;
      if (conv_end) result <= conv_data;
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SAMP_W      = 5,
  parameter int CONV_TICKS  = 12,
  parameter int ABORT_TICKS = 2,
  parameter int NUM_EXT     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               samp_sw,
  input  logic [SEL_W-1:0]   trig_sel,
  input  logic [SAMP_W-1:0]  auto_cnt,
  input  logic               tick,
  input  logic [NUM_EXT-1:0] ext_trig,
  input  logic [DATA_W-1:0]  conv_data,
  output logic               sample_hold,
  output logic               converting,
  output logic [DATA_W-1:0]  result,
  output logic               done
);
  logic [NUM_EXT-1:0] pend;
  logic               conv_end;

  adc_trig_sync #(.NUM_EXT(NUM_EXT)) u_sync (
    .clk(clk), .rst(rst), .tick(tick), .ext_in(ext_trig), .pend(pend)
  );

  adc_seq_fsm #(
    .SAMP_W(SAMP_W), .CONV_TICKS(CONV_TICKS),
    .ABORT_TICKS(ABORT_TICKS), .NUM_EXT(NUM_EXT)
  ) u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .samp_sw(samp_sw),
    .trig_sel(trig_sel), .auto_cnt(auto_cnt), .tick(tick), .pend(pend),
    .sh_q(sample_hold), .cv_q(converting), .conv_end(conv_end)
  );

  adc_result_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .conv_end(conv_end), .conv_data(conv_data),
    .result(result), .done(done)
  );

  assert_done_after_conv_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(converting));
  assert_no_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !converting && !sample_hold);
endmodule

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0, samp_sw = 1'b0, tick = 1'b0;
  logic [2:0]    trig_sel = 3'd0, ext_trig = 3'd0;
  logic [4:0]    auto_cnt = 5'd1;
  logic [DW-1:0] conv_data = '0;
  logic          sample_hold, converting, done;
  logic [DW-1:0] result;

  always #10 clk = ~clk;

  adc_seq_top i_adc_seq_top (
    .clk(clk), .rst(rst), .enable(enable), .samp_sw(samp_sw),
    .trig_sel(trig_sel), .auto_cnt(auto_cnt), .tick(tick),
    .ext_trig(ext_trig), .conv_data(conv_data),
    .sample_hold(sample_hold), .converting(converting),
    .result(result), .done(done)
  );

  // behavioural reference: 0 idle, 1 acquire, 2 convert, 3 recovery
  int           m_st = 0, m_cnt = 0;
  bit [2:0]     s1, s2, s3, pnd;
  bit [DW-1:0]  m_res;
  bit           m_done, m_sh, m_cv;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; s1 = 0; s2 = 0; s3 = 0; pnd = 0;
      m_res = 0; m_done = 0; m_sh = 0; m_cv = 0;
    end else begin
      bit [2:0] ed;
      int eff, nst, ncnt;
      bit hit, fin;
      ed   = s2 & ~s3;
      eff  = (auto_cnt == 0) ? 1 : int'(auto_cnt);
      hit  = (trig_sel >= 1 && trig_sel <= 3) ? pnd[trig_sel - 3'd1] : 1'b0;
      nst  = m_st; ncnt = m_cnt; fin = 0;
      if (m_st == 0) begin
        if (enable && (trig_sel != 0 || samp_sw)) begin nst = 1; ncnt = 0; end
      end else if (m_st == 1) begin
        if (!enable) begin nst = 3; ncnt = 0; end
        else if (tick) begin
          if (trig_sel == 7) begin
            if (m_cnt + 1 >= eff) begin nst = 2; ncnt = 0; end else ncnt = m_cnt + 1;
          end else if (trig_sel == 0) begin
            if (!samp_sw) begin nst = 2; ncnt = 0; end
          end else if (hit) begin nst = 2; ncnt = 0; end
        end
      end else if (m_st == 2) begin
        if (!enable) begin nst = 3; ncnt = 0; end
        else if (tick) begin
          if (m_cnt == 11) begin nst = 0; ncnt = 0; fin = 1; end else ncnt = m_cnt + 1;
        end
      end else begin
        if (tick) begin
          if (m_cnt == 1) begin nst = 0; ncnt = 0; end else ncnt = m_cnt + 1;
        end
      end
      pnd = tick ? ed : (pnd | ed);
      s3 = s2; s2 = s1; s1 = ext_trig;
      m_done = fin;
      if (fin) m_res = conv_data;
      m_st = nst; m_cnt = ncnt;
      m_sh = (nst == 1); m_cv = (nst == 2);
    end
  end

  int vectors = 0, miscompares = 0, dones = 0, cv_cycles = 0, tcnt = 0, tper = 2;
  int cycles = 0;
  bit finished = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input string req);
    @(negedge clk);
    vectors++;
    if ({sample_hold, converting, done} !== {m_sh, m_cv, m_done} || result !== m_res) begin
      miscompares++;
      $display("FAIL %s: actual sh=%b cv=%b done=%b res=%h expected sh=%b cv=%b done=%b res=%h",
               req, sample_hold, converting, done, result, m_sh, m_cv, m_done, m_res);
    end
    if (done === 1'b1) dones++;
    if (converting === 1'b1) cv_cycles++;
    tcnt++;
    tick = (tcnt % tper == 0);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  initial begin
    int r0;
    run(4, "R1");
    chk({sample_hold, converting, done} == 3'b000 && result == 0, "R1 reset outputs", int'(result), 0);
    rst = 1'b0;
    step("R1");
    chk({sample_hold, converting, done} == 3'b000 && result == 0, "R1 first cycle", int'({sample_hold, converting, done}), 0);

    // software mode
    conv_data = 10'h2A5; enable = 1'b1; trig_sel = 3'd0; samp_sw = 1'b1;
    run(3, "R2");
    chk(sample_hold == 1'b1, "R2 acquiring", int'(sample_hold), 1);
    run(10, "R2");
    chk(converting == 1'b0, "R2 no start while bit high", int'(converting), 0);
    dones = 0; cv_cycles = 0; samp_sw = 1'b0;
    run(40, "R5");
    chk(dones == 1, "R5 single done", dones, 1);
    chk(cv_cycles == 24, "R5 conversion length 12 ticks", cv_cycles, 24);
    chk(result == 10'h2A5, "R5 stored word", int'(result), 'h2A5);

    // auto-start, tick period 3
    tper = 3; trig_sel = 3'd7; auto_cnt = 5'd3; conv_data = 10'h111; dones = 0;
    run(300, "R3");
    chk(dones >= 5 && dones <= 7, "R3 repeated auto conversions", dones, 6);
    tper = 2; auto_cnt = 5'd0; dones = 0; conv_data = 10'h0F0;
    run(200, "R4");
    chk(dones >= 6, "R4 zero count still converts", dones, 7);
    chk(result == 10'h0F0, "R4 result", int'(result), 'h0F0);

    // stop and idle
    enable = 1'b0; run(10, "R8"); enable = 1'b1;

    // external sources
    for (int k = 0; k < 3; k++) begin
      trig_sel = 3'(k + 1); conv_data = 10'(k + 5); dones = 0;
      run(6, "R6");
      ext_trig = 3'(1 << ((k + 1) % 3));
      run(3, "R6"); ext_trig = 3'd0;
      run(12, "R6");
      chk(dones == 0 && converting == 0, "R6 unselected bit ignored", int'(converting), 0);
      ext_trig = 3'(1 << k);
      run(3, "R6"); ext_trig = 3'd0;
      run(40, "R6");
      chk(dones == 1, "R6 selected event converts", dones, 1);
      chk(result == 10'(k + 5), "R6 result", int'(result), k + 5);
    end

    // unused codes
    for (int c = 4; c < 7; c++) begin
      trig_sel = 3'(c); dones = 0;
      run(60, "R7");
      chk(sample_hold == 1'b1 && converting == 1'b0 && dones == 0, "R7 stays acquiring",
          int'({sample_hold, converting}), 2);
    end
    enable = 1'b0; run(10, "R8"); enable = 1'b1;

    // abort during conversion
    trig_sel = 3'd7; auto_cnt = 5'd1; conv_data = 10'h155;
    for (int i = 0; i < 100 && converting !== 1'b1; i++) step("R8");
    run(6, "R8");
    r0 = int'(result); conv_data = 10'h0AA; dones = 0; enable = 1'b0;
    run(40, "R8");
    chk(dones == 0 && int'(result) == r0, "R8 result kept", int'(result), r0);

    // abort coinciding with auto-start, then recovery wait
    auto_cnt = 5'd2; enable = 1'b1;
    for (int i = 0; i < 200; i++) begin
      step("R9");
      if (tick && m_st == 1 && m_cnt + 1 >= 2) begin enable = 1'b0; break; end
    end
    step("R9");
    chk(converting == 1'b0 && sample_hold == 1'b0, "R9 abort wins", int'(converting), 0);
    enable = 1'b1;
    cv_cycles = 0;
    begin
      int sh_seen = 0;
      for (int i = 0; i < 3; i++) begin step("R10"); if (sample_hold) sh_seen++; end
      chk(sh_seen == 0, "R10 recovery wait", sh_seen, 0);
      sh_seen = 0;
      for (int i = 0; i < 6; i++) begin step("R10"); if (sample_hold) sh_seen++; end
      chk(sh_seen > 0, "R10 sampling resumes", sh_seen, 1);
    end
    run(100, "R11");
    chk(!(sample_hold && converting), "R11 exclusive", int'({sample_hold, converting}), 0);
    summary();
  end
endmodule